// File: doc/BRIEF.md
# Binary Dot-Product Unit with Per-Channel Scaling

This block computes one output-channel value of a binarized neural-network layer. Weight and activation vectors hold one bit per element. A set bit stands for +1 and a clear bit stands for -1. Both operands arrive packed, one word of each per cycle. Each word comes with its own element mask. A last flag closes the vector. For every enabled element, the unit compares the weight bit with the activation bit (XNOR) and counts the agreements. It sums these counts across the words of the vector. When the vector ends, it forms the signed dot product from the agreement count and the element count.

The signed dot product is then multiplied by a signed fixed-point scale for the channel named with the last word. Each channel keeps its own scale, loaded through a small write port. The unit also produces a one-bit sign of the scaled value, which a following binary layer can use as its input. Results appear, registered, on a single-cycle output strobe. The internal sums clear on their own, so the next vector may start in the cycle that follows.

Top module: `bdot_unit`

## Requirements
- R1: Bit value 1 encodes +1 and bit value 0 encodes -1, for both operands. A full word whose weight and activation bits all agree gives a dot product of +WORD_W, and one where they all disagree gives -WORD_W.
- R2: The dot product equals 2·P − N. P is the number of enabled positions where weight bit equals activation bit (XNOR is 1), and N is the number of enabled positions.
- R3: P and N accumulate over every accepted word of a vector, up to and including the word carrying `in_last`.
- R4: Bit i of `in_mask` set to 1 enables element i of that word. A masked-off bit adds to neither P nor N, and a mask of all zeros contributes nothing.
- R5: Each channel holds a signed Q8.8 scale (16 bits, 8 fractional bits). A write with `cfg_we` high stores `cfg_alpha` for channel `cfg_ch` at the clock edge. `out_scaled` is the exact product dot × scale as a raw integer with 8 fractional bits, and it uses the scale of channel `in_ch` sampled with the last word.
- R6: `out_bit` is 1 when `out_scaled` is greater than or equal to zero, including exactly zero, and 0 when it is negative.
- R7: `out_valid` is high for exactly the one cycle after the clock edge that accepts a word with `in_last` high. `out_dot`, `out_scaled`, `out_bit` and `out_ch` hold their values until the next such result.
- R8: Once a vector ends, the accumulation restarts from zero. Back-to-back vectors on consecutive cycles each produce their own independent result.
- R9: Synchronous active-high `rst` clears the running sums, `out_valid` and the result registers, and returns every channel scale to 1.0 (0x0100).
- R10: While `in_valid` is low, the operand, mask, last and channel inputs have no effect on the running sums or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand word present this cycle |
| in_last | input | 1 | Word is the final one of the vector |
| in_ch | input | CH_W | Output channel, sampled with the last word |
| in_wgt | input | WORD_W | Packed weight bits |
| in_act | input | WORD_W | Packed activation bits |
| in_mask | input | WORD_W | Element enable per bit position |
| cfg_we | input | 1 | Scale write strobe |
| cfg_ch | input | CH_W | Channel whose scale is written |
| cfg_alpha | input | ALPHA_W | Signed Q8.8 scale value |
| out_valid | output | 1 | Single-cycle result strobe |
| out_ch | output | CH_W | Channel of the result |
| out_dot | output | DOT_W | Signed dot product |
| out_scaled | output | SC_W | Signed scaled result, 8 fractional bits |
| out_bit | output | 1 | Sign binarization of the scaled result |

## Verification
If the running sums keep a stale value, the error shows in `out_dot` of the very next vector. This appears one cycle after its last word, so the tests include back-to-back vectors and a reset in the middle of a vector. Mask or XNOR errors turn up as a wrong dot product on single-word vectors whose values are easy to work out by hand. A scale stored in the wrong channel, or left unreset, is exposed by vectors run on two channels with different scales, and by re-reading a scale after reset. A strobe that is too long or appears when it should not is caught in the cycle right after the expected pulse.

// File: rtl/bdot_pkg.sv
package bdot_pkg;
   localparam int ALPHA_W    = 16;
   localparam int ALPHA_FRAC = 8;
   localparam logic signed [ALPHA_W-1:0] ALPHA_ONE = ALPHA_W'(1 << ALPHA_FRAC);

   function automatic int cnt_width(input int word_w, input int max_words);
      return $clog2(word_w * max_words + 1);
   endfunction
endpackage

// File: rtl/bdot_popcnt.sv
module bdot_popcnt #(
   parameter int WORD_W = 32,
   parameter int PC_W   = $clog2(WORD_W + 1)
) (
   input  logic [WORD_W-1:0] wgt,
   input  logic [WORD_W-1:0] act,
   input  logic [WORD_W-1:0] mask,
   output logic [PC_W-1:0]   match_cnt,
   output logic [PC_W-1:0]   elem_cnt
);
   logic [WORD_W-1:0] agree;

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign agree[i] = ~(wgt[i] ^ act[i]) & mask[i];
   end

   always_comb begin
      match_cnt = '0;
      elem_cnt  = '0;
      for (int i = 0; i < WORD_W; i++) begin
         match_cnt = match_cnt + PC_W'(agree[i]);
         elem_cnt  = elem_cnt + PC_W'(mask[i]);
      end
   end
endmodule

// File: rtl/bdot_accum.sv
module bdot_accum #(
   parameter int PC_W  = 6,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [PC_W-1:0]  match_cnt,
   input  logic [PC_W-1:0]  elem_cnt,
   output logic [CNT_W-1:0] tot_p,
   output logic [CNT_W-1:0] tot_n,
   output logic             fin_stb
);
   logic [CNT_W-1:0] acc_p, acc_n;

   assign tot_p   = acc_p + CNT_W'(match_cnt);
   assign tot_n   = acc_n + CNT_W'(elem_cnt);
   assign fin_stb = in_valid & in_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_p <= '0;
         acc_n <= '0;
      end else if (in_valid) begin
         if (in_last) begin
            acc_p <= '0;
            acc_n <= '0;
         end else begin
            acc_p <= tot_p;
            acc_n <= tot_n;
         end
      end
   end
endmodule

// File: rtl/bdot_scale.sv
module bdot_scale
   import bdot_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH),
   parameter int DOT_W  = 14,
   parameter int SC_W   = DOT_W + ALPHA_W,
   parameter bit BIN_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [CH_W-1:0]           cfg_ch,
   input  logic signed [ALPHA_W-1:0] cfg_alpha,
   input  logic                      fin_stb,
   input  logic [CH_W-1:0]           rd_ch,
   input  logic signed [DOT_W-1:0]   dot,
   output logic                      out_valid,
   output logic [CH_W-1:0]           out_ch,
   output logic signed [DOT_W-1:0]   out_dot,
   output logic signed [SC_W-1:0]    out_scaled,
   output logic                      out_bit
);
   logic signed [ALPHA_W-1:0] alpha_q [NUM_CH];
   logic signed [ALPHA_W-1:0] alpha_sel;
   logic signed [SC_W-1:0]    d_ext, a_ext, prod;
   logic                      bit_d;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_alpha
      always_ff @(posedge clk) begin
         if (rst)
            alpha_q[c] <= ALPHA_ONE;
         else if (cfg_we && (cfg_ch == CH_W'(c)))
            alpha_q[c] <= cfg_alpha;
      end
   end

   assign alpha_sel = alpha_q[rd_ch];
   assign d_ext     = SC_W'(dot);
   assign a_ext     = SC_W'(alpha_sel);
   assign prod      = d_ext * a_ext;

   if (BIN_EN) begin : g_bin
      assign bit_d = ~prod[SC_W-1];
   end else begin : g_nobin
      assign bit_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_ch     <= '0;
         out_dot    <= '0;
         out_scaled <= '0;
         out_bit    <= 1'b0;
      end else begin
         out_valid <= fin_stb;
         if (fin_stb) begin
            out_ch     <= rd_ch;
            out_dot    <= dot;
            out_scaled <= prod;
            out_bit    <= bit_d;
         end
      end
   end
endmodule

// File: rtl/bdot_unit.sv
module bdot_unit
   import bdot_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 64,
   parameter int NUM_CH    = 16,
   parameter bit BIN_EN    = 1'b1,
   parameter int CH_W      = $clog2(NUM_CH),
   parameter int PC_W      = $clog2(WORD_W + 1),
   parameter int CNT_W     = cnt_width(WORD_W, MAX_WORDS),
   parameter int DOT_W     = CNT_W + 2,
   parameter int SC_W      = DOT_W + ALPHA_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic                      in_last,
   input  logic [CH_W-1:0]           in_ch,
   input  logic [WORD_W-1:0]         in_wgt,
   input  logic [WORD_W-1:0]         in_act,
   input  logic [WORD_W-1:0]         in_mask,
   input  logic                      cfg_we,
   input  logic [CH_W-1:0]           cfg_ch,
   input  logic signed [ALPHA_W-1:0] cfg_alpha,
   output logic                      out_valid,
   output logic [CH_W-1:0]           out_ch,
   output logic signed [DOT_W-1:0]   out_dot,
   output logic signed [SC_W-1:0]    out_scaled,
   output logic                      out_bit
);
   if (WORD_W < 1) begin : g_bad_word
      $error("bdot_unit: WORD_W must be at least 1");
   end
   if (MAX_WORDS < 1) begin : g_bad_words
      $error("bdot_unit: MAX_WORDS must be at least 1");
   end
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("bdot_unit: NUM_CH must be a power of two, at least 2");
   end

   logic [PC_W-1:0]         match_cnt, elem_cnt;
   logic [CNT_W-1:0]        tot_p, tot_n;
   logic                    fin_stb;
   logic signed [DOT_W-1:0] dot;

   bdot_popcnt #(.WORD_W(WORD_W), .PC_W(PC_W)) u_pop (
      .wgt       (in_wgt),
      .act       (in_act),
      .mask      (in_mask),
      .match_cnt (match_cnt),
      .elem_cnt  (elem_cnt)
   );

   bdot_accum #(.PC_W(PC_W), .CNT_W(CNT_W)) u_acc (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .match_cnt (match_cnt),
      .elem_cnt  (elem_cnt),
      .tot_p     (tot_p),
      .tot_n     (tot_n),
      .fin_stb   (fin_stb)
   );

   assign dot = $signed({1'b0, tot_p, 1'b0}) - $signed({2'b00, tot_n});

   bdot_scale #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .DOT_W  (DOT_W),
      .SC_W   (SC_W),
      .BIN_EN (BIN_EN)
   ) u_scl (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we),
      .cfg_ch     (cfg_ch),
      .cfg_alpha  (cfg_alpha),
      .fin_stb    (fin_stb),
      .rd_ch      (in_ch),
      .dot        (dot),
      .out_valid  (out_valid),
      .out_ch     (out_ch),
      .out_dot    (out_dot),
      .out_scaled (out_scaled),
      .out_bit    (out_bit)
   );
endmodule

// File: rtl/bdot_chk.sv
module bdot_chk #(
   parameter int DOT_W     = 14,
   parameter int SC_W      = 30,
   parameter int MAX_ELEMS = 2048,
   parameter bit BIN_EN    = 1'b1
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    in_last,
   input logic                    out_valid,
   input logic signed [DOT_W-1:0] out_dot,
   input logic signed [SC_W-1:0]  out_scaled,
   input logic                    out_bit
);
   localparam logic signed [DOT_W-1:0] LIM = DOT_W'(MAX_ELEMS);

   assert_pulse_after_last_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_last) |=> out_valid);

   assert_no_stray_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_last) |=> !out_valid);

   assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_last) |=> ($stable(out_dot) && $stable(out_scaled)));

   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && out_dot == '0 && out_scaled == '0));

   assert_zero_dot_scales_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_dot == '0) |-> (out_scaled == '0));

   assert_dot_in_range_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_dot <= LIM && out_dot >= -LIM));

   if (BIN_EN) begin : g_bin_chk
      assert_zero_maps_plus_R6: assert property (@(posedge clk) disable iff (rst)
         (out_valid && out_scaled == '0) |-> out_bit);
      assert_negative_maps_minus_R6: assert property (@(posedge clk) disable iff (rst)
         (out_valid && out_scaled < 0) |-> !out_bit);
   end
endmodule

bind bdot_unit bdot_chk #(
   .DOT_W     (DOT_W),
   .SC_W      (SC_W),
   .MAX_ELEMS (WORD_W * MAX_WORDS),
   .BIN_EN    (BIN_EN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_last    (in_last),
   .out_valid  (out_valid),
   .out_dot    (out_dot),
   .out_scaled (out_scaled),
   .out_bit    (out_bit)
);

// File: tb/tb_bdot_unit.sv
module tb_bdot_unit;
   localparam int CLK_P = 10;
   localparam int W     = 32;
   localparam int NT    = 8;

   localparam logic [W-1:0] TW [NT] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_0000,
                                        32'h0000_000F, 32'h0000_00AA, 32'h0000_0001, 32'h1234_5678};
   localparam logic [W-1:0] TA [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000,
                                        32'h0000_0000, 32'h0000_00FF, 32'h0000_0001, 32'h9ABC_DEF0};
   localparam logic [W-1:0] TM [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000F,
                                        32'h0000_000F, 32'h0000_00FF, 32'h0000_0007, 32'h0000_0000};
   localparam int           TD [NT] = '{32, -32, 0, 4, -4, 0, 3, 0};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0, in_last = 1'b0, cfg_we = 1'b0;
   logic [3:0] in_ch = '0, cfg_ch = '0;
   logic [W-1:0] in_wgt = '0, in_act = '0, in_mask = '0;
   logic signed [15:0] cfg_alpha = '0;
   logic out_valid, out_bit;
   logic [3:0] out_ch;
   logic signed [13:0] out_dot;
   logic signed [29:0] out_scaled;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   bdot_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_ch(in_ch),
      .in_wgt(in_wgt), .in_act(in_act), .in_mask(in_mask), .cfg_we(cfg_we),
      .cfg_ch(cfg_ch), .cfg_alpha(cfg_alpha), .out_valid(out_valid), .out_ch(out_ch),
      .out_dot(out_dot), .out_scaled(out_scaled), .out_bit(out_bit)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input logic [W-1:0] w, input logic [W-1:0] a, input logic [W-1:0] m,
                      input logic last, input logic [3:0] ch);
      @(negedge clk);
      in_valid = 1'b1; in_last = last; in_wgt = w; in_act = a; in_mask = m; in_ch = ch;
   endtask

   task automatic idle_garbage();
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b1; in_wgt = 32'hDEAD_BEEF; in_act = 32'h0F0F_0F0F;
      in_mask = 32'hFFFF_FFFF; in_ch = 4'd7;
   endtask

   task automatic expect_res(input string req, input int dot, input int alpha, input logic [3:0] ch);
      longint sc;
      sc = longint'(dot) * longint'(alpha);
      chk({req, " valid"}, longint'(out_valid), 1);
      chk({req, " dot"}, longint'(out_dot), longint'(dot));
      chk({req, " scaled"}, longint'(out_scaled), sc);
      chk({req, " bit"}, longint'(out_bit), (sc >= 0) ? 1 : 0);
      chk({req, " ch"}, longint'(out_ch), longint'(ch));
   endtask

   task automatic wr_alpha(input logic [3:0] ch, input logic signed [15:0] v);
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b1; cfg_ch = ch; cfg_alpha = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset valid", longint'(out_valid), 0);
      chk("R9 reset dot", longint'(out_dot), 0);
      chk("R9 reset scaled", longint'(out_scaled), 0);
      rst = 1'b0;

      // R1 R2 R4 R6: single-word table, default scale 1.0 on channel 0
      for (int i = 0; i < NT; i++) begin
         put(TW[i], TA[i], TM[i], 1'b1, 4'd0);
         idle_garbage();
         expect_res($sformatf("R2 table%0d", i), TD[i], 256, 4'd0);
      end

      // R7: strobe is a single cycle
      @(negedge clk);
      chk("R7 pulse width", longint'(out_valid), 0);
      chk("R7 held dot", longint'(out_dot), 0);

      // R5: per-channel scales, negative scale, zero dot maps to +1 (R6)
      wr_alpha(4'd3, -16'sd640);
      wr_alpha(4'd5, 16'sd384);
      put(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd3);
      idle_garbage();
      expect_res("R5 ch3 negative", 32, -640, 4'd3);
      put(32'h0, 32'h0, 32'h0000_000F, 1'b1, 4'd5);
      put(32'hF, 32'h0, 32'h0000_000F, 1'b1, 4'd5);
      // R8: back-to-back results
      expect_res("R8 first of pair", 4, 384, 4'd5);
      idle_garbage();
      expect_res("R8 second of pair", -4, 384, 4'd5);
      put(32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd3);
      idle_garbage();
      expect_res("R6 zero with negative scale", 0, -640, 4'd3);

      // R3 R10: multi-word vector with idle garbage words between beats
      put(32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b0, 4'd0);
      idle_garbage();
      idle_garbage();
      chk("R10 no strobe on idle", longint'(out_valid), 0);
      put(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'd0);
      idle_garbage();
      put(32'h0000_0003, 32'h0000_0003, 32'h0000_0003, 1'b1, 4'd0);
      idle_garbage();
      expect_res("R3 three words", 2, 256, 4'd0);

      // R9: reset in mid-vector clears sums and restores scales
      put(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'd3);
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 mid reset valid", longint'(out_valid), 0);
      put(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd3);
      idle_garbage();
      expect_res("R9 sums cleared scale restored", -32, 256, 4'd3);

      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule